// File: doc/BRIEF.md
# I2C Slave Address Recognition

This block decides whether an I2C slave should acknowledge the address phase of a transfer. A bit-level front end, which is not part of this block, delivers each received byte with a valid strobe. It flags the byte that follows a START or repeated START, and it reports STOP conditions. The block compares the incoming address against a configured own address. That address is 7-bit or 10-bit. The comparison applies a per-bit don't-care mask. The block rejects every address pattern the bus protocol reserves, whatever the mask is. It handles general call under an enable bit.

In 10-bit mode the block follows the two-byte sequence. The first byte is matched on its two upper address bits and acknowledged as a partial match. The following byte completes the match. Once a full match has been seen, a repeated START that carries the upper byte with the read bit set is acknowledged directly. A management-mode enable switches the mask off. While that enable is set, only an exact address compare is made.

The decision is registered. It appears one clock after the byte strobe as a one-cycle `ack_vld` pulse together with `ack`. The `matched`, `gcall_hit` and `rw_bit` status lines hold until the next address byte or a STOP.

Top module: `i2c_addr_recog`

## Requirements
- R1: A set bit of `addr_mask` makes that address bit match either value. With own address 0x00, mask 0x20 and 7-bit mode, the first bytes 0x40 and 0x41 (address 0100000) are acknowledged. The same holds for bits 9..8 and 7..0 in 10-bit mode.
- R2: While `mgmt_en` is 1 the mask is ignored. An address that matches only through the mask is not acknowledged.
- R3: First byte 0x00 (general call) is acknowledged only when `gcall_en` is 1. In that case `gcall_hit` goes to 1, `matched` stays 0 and `rw_bit` becomes 0. When `gcall_en` is 0 the byte is not acknowledged and `gcall_hit` stays 0.
- R4: Some first-byte values are never acknowledged under any mask or own address. These are byte 0x01 (address 0000000, read), addresses 0000001 to 0000111, and addresses 11111xx (bytes 0xF8 to 0xFF).
- R5: Addresses 11110xx (bytes 0xF0 to 0xF7) are never acknowledged in 7-bit mode. In 10-bit mode, only a first byte of the form 11110xx can be acknowledged, apart from general call.
- R6: In 10-bit mode, a first byte 11110 A9 A8 0 whose bits 2..1 match `own_addr[9:8]` after masking is acknowledged with `matched` 0. The next non-first byte is then compared with `own_addr[7:0]` after masking. On a match it is acknowledged and sets `matched` to 1 and `rw_bit` to 0.
- R7: After a full 10-bit match, a repeated START with first byte 11110 A9 A8 1 that matches the upper bits is acknowledged. It sets `matched` to 1 and `rw_bit` to 1. Without a previous full match, the same byte is not acknowledged.
- R8: A STOP, or a first byte that is not acknowledged, clears the partial and full 10-bit state and drops `matched` and `gcall_hit`. A following non-first byte is not acknowledged.
- R9: `ack_vld` pulses for exactly one cycle, one clock after each `byte_vld` that is not accompanied by `stop_det`. Bytes outside an address phase give `ack_vld` 1 with `ack` 0. STOP has priority over a byte strobe in the same cycle.
- R10: In 7-bit mode, a first byte whose bits 7..1 match `own_addr[6:0]` after masking is acknowledged. It sets `matched` to 1 and `rw_bit` to bit 0 of the byte.
- R11: A synchronous active-high `rst` returns all outputs and the sequence state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present on `rx_byte` |
| addr_first | input | 1 | The present byte is the first one after START or repeated START |
| stop_det | input | 1 | A STOP condition was seen |
| rx_byte | input | 8 | Received byte, bit 0 is the R/W bit on address bytes |
| own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode |
| addr_mask | input | 10 | Per-bit don't-care mask, 1 = ignore the bit |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| gcall_en | input | 1 | 1 allows the general call to be acknowledged |
| mgmt_en | input | 1 | 1 disables the mask |
| ack_vld | output | 1 | One-cycle pulse: `ack` holds the decision for the last byte |
| ack | output | 1 | Acknowledge decision |
| matched | output | 1 | A full own-address match is active |
| gcall_hit | output | 1 | An acknowledged general call is active |
| rw_bit | output | 1 | R/W direction captured from the last acknowledged address |

## Verification
The checker watches a set of properties on every cycle. These are the one-cycle timing of `ack_vld`, the rejection of the reserved byte ranges and of 11110xx in 7-bit mode, the general-call gating, and the exclusivity of `matched` and `gcall_hit`. It also checks that STOP clears state and that a second byte is acknowledged only while a partial 10-bit match is pending. Other behaviour can only be shown by the bench's scenarios. This covers the masked comparison itself, the effect of `mgmt_en`, the two-byte 10-bit sequence and the repeated-START read after a full match. It also covers the captured direction bit. The bench compares these against its own model across random configurations and byte streams.

// File: rtl/i2c_arp_pkg.sv
package i2c_arp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int A7_W   = 7;
  localparam int HI_W   = ADDR_W - BYTE_W;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_GCALL  = 2'd1,
    CLS_RESV   = 2'd2,
    CLS_TEN_HI = 2'd3
  } byte_cls_e;

  // Sort the 7-bit address field of a first byte into protocol classes.
  function automatic byte_cls_e classify(input logic [BYTE_W-1:0] b);
    logic [A7_W-1:0] a;
    a = b[BYTE_W-1:1];
    if (a == '0 && !b[0])             return CLS_GCALL;
    else if (a[A7_W-1:3] == 4'b0000)  return CLS_RESV;
    else if (a[A7_W-1:2] == 5'b11111) return CLS_RESV;
    else if (a[A7_W-1:2] == 5'b11110) return CLS_TEN_HI;
    else                              return CLS_PLAIN;
  endfunction

  // Mask actually applied: cleared when the management mode is on.
  function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] m,
                                                 input logic mgmt);
    return mgmt ? '0 : m;
  endfunction
endpackage

// File: rtl/i2c_arp_compare.sv
module i2c_arp_compare #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx,
  input  logic [W-1:0] own,
  input  logic [W-1:0] dont_care,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = dont_care[i] | ~(rx[i] ^ own[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/i2c_arp_classify.sv
module i2c_arp_classify
  import i2c_arp_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  output byte_cls_e         cls,
  output logic              rw
);
  assign cls = classify(rx_byte);
  assign rw  = rx_byte[0];
endmodule

// File: rtl/i2c_arp_seq.sv
module i2c_arp_seq
  import i2c_arp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      byte_vld,
  input  logic      addr_first,
  input  logic      stop_det,
  input  byte_cls_e cls,
  input  logic      rw,
  input  logic      ten_bit_en,
  input  logic      gcall_en,
  input  logic      hit7,
  input  logic      hit_hi,
  input  logic      hit_lo,
  output logic      ack_vld,
  output logic      ack,
  output logic      matched,
  output logic      gcall_hit,
  output logic      rw_bit,
  output logic      hi_pend,
  output logic      full10
);
  logic dec_ack, nxt_hi, nxt_full, nxt_m, nxt_g, nxt_rw, nxt_av;

  always_comb begin
    dec_ack  = 1'b0;
    nxt_hi   = hi_pend;
    nxt_full = full10;
    nxt_m    = matched;
    nxt_g    = gcall_hit;
    nxt_rw   = rw_bit;
    nxt_av   = byte_vld && !stop_det;
    if (stop_det) begin
      nxt_hi   = 1'b0;
      nxt_full = 1'b0;
      nxt_m    = 1'b0;
      nxt_g    = 1'b0;
    end else if (byte_vld && addr_first) begin
      nxt_hi   = 1'b0;
      nxt_full = 1'b0;
      nxt_m    = 1'b0;
      nxt_g    = 1'b0;
      unique case (cls)
        CLS_GCALL: begin
          if (gcall_en) begin
            dec_ack = 1'b1;
            nxt_g   = 1'b1;
            nxt_rw  = 1'b0;
          end
        end
        CLS_TEN_HI: begin
          if (ten_bit_en && hit_hi) begin
            if (!rw) begin
              dec_ack = 1'b1;
              nxt_hi  = 1'b1;
            end else if (full10) begin
              dec_ack  = 1'b1;
              nxt_full = 1'b1;
              nxt_m    = 1'b1;
              nxt_rw   = 1'b1;
            end
          end
        end
        CLS_PLAIN: begin
          if (!ten_bit_en && hit7) begin
            dec_ack = 1'b1;
            nxt_m   = 1'b1;
            nxt_rw  = rw;
          end
        end
        default: ;
      endcase
    end else if (byte_vld && hi_pend) begin
      nxt_hi = 1'b0;
      if (hit_lo) begin
        dec_ack  = 1'b1;
        nxt_full = 1'b1;
        nxt_m    = 1'b1;
        nxt_rw   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_vld   <= 1'b0;
      ack       <= 1'b0;
      matched   <= 1'b0;
      gcall_hit <= 1'b0;
      rw_bit    <= 1'b0;
      hi_pend   <= 1'b0;
      full10    <= 1'b0;
    end else begin
      ack_vld   <= nxt_av;
      ack       <= dec_ack;
      matched   <= nxt_m;
      gcall_hit <= nxt_g;
      rw_bit    <= nxt_rw;
      hi_pend   <= nxt_hi;
      full10    <= nxt_full;
    end
  end
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_arp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic              addr_first,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              ten_bit_en,
  input  logic              gcall_en,
  input  logic              mgmt_en,
  output logic              ack_vld,
  output logic              ack,
  output logic              matched,
  output logic              gcall_hit,
  output logic              rw_bit
);
  logic [ADDR_W-1:0] mask_w;
  byte_cls_e         cls_w;
  logic              rw_w;
  logic              hit7_w, hit_hi_w, hit_lo_w;
  logic              hi_pend_w, full10_w;

  assign mask_w = eff_mask(addr_mask, mgmt_en);

  i2c_arp_classify u_cls (
    .rx_byte (rx_byte),
    .cls     (cls_w),
    .rw      (rw_w)
  );

  i2c_arp_compare #(.W(A7_W)) u_cmp7 (
    .rx        (rx_byte[BYTE_W-1:1]),
    .own       (own_addr[A7_W-1:0]),
    .dont_care (mask_w[A7_W-1:0]),
    .hit       (hit7_w)
  );

  i2c_arp_compare #(.W(HI_W)) u_cmp_hi (
    .rx        (rx_byte[HI_W:1]),
    .own       (own_addr[ADDR_W-1:BYTE_W]),
    .dont_care (mask_w[ADDR_W-1:BYTE_W]),
    .hit       (hit_hi_w)
  );

  i2c_arp_compare #(.W(BYTE_W)) u_cmp_lo (
    .rx        (rx_byte),
    .own       (own_addr[BYTE_W-1:0]),
    .dont_care (mask_w[BYTE_W-1:0]),
    .hit       (hit_lo_w)
  );

  i2c_arp_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .addr_first (addr_first),
    .stop_det   (stop_det),
    .cls        (cls_w),
    .rw         (rw_w),
    .ten_bit_en (ten_bit_en),
    .gcall_en   (gcall_en),
    .hit7       (hit7_w),
    .hit_hi     (hit_hi_w),
    .hit_lo     (hit_lo_w),
    .ack_vld    (ack_vld),
    .ack        (ack),
    .matched    (matched),
    .gcall_hit  (gcall_hit),
    .rw_bit     (rw_bit),
    .hi_pend    (hi_pend_w),
    .full10     (full10_w)
  );
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic       addr_first,
  input logic       stop_det,
  input logic [7:0] rx_byte,
  input logic       ten_bit_en,
  input logic       gcall_en,
  input logic       ack_vld,
  input logic       ack,
  input logic       matched,
  input logic       gcall_hit,
  input logic       hi_pend_w
);
  logic resv_byte, ten_hi_byte, first_strobe;
  assign resv_byte    = (rx_byte[7:4] == 4'h0 && rx_byte != 8'h00) || rx_byte[7:3] == 5'b11111;
  assign ten_hi_byte  = rx_byte[7:3] == 5'b11110;
  assign first_strobe = byte_vld && addr_first && !stop_det;

  assert_ack_vld_timing_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(byte_vld && !stop_det)) |-> ack_vld);
  assert_ack_vld_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(byte_vld && !stop_det)) |-> !ack_vld);
  assert_ack_needs_vld_R9: assert property (@(posedge clk) disable iff (rst)
    ack |-> ack_vld);
  assert_reserved_nack_R4: assert property (@(posedge clk) disable iff (rst)
    (first_strobe && resv_byte) |=> !ack);
  assert_ten_hi_7bit_R5: assert property (@(posedge clk) disable iff (rst)
    (first_strobe && ten_hi_byte && !ten_bit_en) |=> !ack);
  assert_gcall_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (first_strobe && rx_byte == 8'h00 && !gcall_en) |=> (!ack && !gcall_hit));
  assert_excl_flags_R3: assert property (@(posedge clk) disable iff (rst)
    !(matched && gcall_hit));
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!matched && !gcall_hit && !ack && !hi_pend_w));
  assert_second_needs_pend_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !addr_first && !stop_det && !hi_pend_w) |=> !ack);
endmodule

bind i2c_addr_recog i2c_addr_recog_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_vld   (byte_vld),
  .addr_first (addr_first),
  .stop_det   (stop_det),
  .rx_byte    (rx_byte),
  .ten_bit_en (ten_bit_en),
  .gcall_en   (gcall_en),
  .ack_vld    (ack_vld),
  .ack        (ack),
  .matched    (matched),
  .gcall_hit  (gcall_hit),
  .hi_pend_w  (hi_pend_w)
);

// File: tb/i2c_addr_recog_bench.sv
module i2c_addr_recog_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0, addr_first = 1'b0, stop_det = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [9:0] own_addr = '0, addr_mask = '0;
  logic       ten_bit_en = 1'b0, gcall_en = 1'b0, mgmt_en = 1'b0;
  logic       ack_vld, ack, matched, gcall_hit, rw_bit;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic m_hi = 0, m_full = 0, m_match = 0, m_gc = 0, m_rw = 0;
  logic e_av = 0, e_ack = 0;

  always #5 clk = ~clk;

  i2c_addr_recog u_i2c_addr_recog (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .addr_first(addr_first),
    .stop_det(stop_det), .rx_byte(rx_byte), .own_addr(own_addr),
    .addr_mask(addr_mask), .ten_bit_en(ten_bit_en), .gcall_en(gcall_en),
    .mgmt_en(mgmt_en), .ack_vld(ack_vld), .ack(ack), .matched(matched),
    .gcall_hit(gcall_hit), .rw_bit(rw_bit)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic bits_match(input logic [9:0] rx, own, msk, input int lo, hi);
    logic ok = 1'b1;
    for (int i = lo; i <= hi; i++)
      if (!msk[i] && rx[i] != own[i]) ok = 1'b0;
    return ok;
  endfunction

  task automatic model(input logic f, input logic s, input logic [7:0] b);
    logic [6:0] a;
    logic [9:0] em;
    a  = b[7:1];
    em = mgmt_en ? 10'd0 : addr_mask;
    e_av  = !s;
    e_ack = 1'b0;
    if (s) begin
      m_hi = 0; m_full = 0; m_match = 0; m_gc = 0;
    end else if (f) begin
      logic keep_full;
      keep_full = 1'b0;
      m_hi = 0; m_match = 0; m_gc = 0;
      if (b == 8'h00) begin
        if (gcall_en) begin e_ack = 1; m_gc = 1; m_rw = 0; end
      end else if (a < 7'd8 || a >= 7'h7C) begin
        e_ack = 0;
      end else if (a >= 7'h78) begin
        if (ten_bit_en && bits_match({a[1:0], 8'h00}, own_addr, em, 8, 9)) begin
          if (b[0] == 1'b0) begin e_ack = 1; m_hi = 1; end
          else if (m_full) begin e_ack = 1; keep_full = 1; m_match = 1; m_rw = 1; end
        end
      end else if (!ten_bit_en && bits_match({3'b0, a}, own_addr, em, 0, 6)) begin
        e_ack = 1; m_match = 1; m_rw = b[0];
      end
      m_full = keep_full;
    end else if (m_hi) begin
      m_hi = 0;
      if (bits_match({2'b0, b}, own_addr, em, 0, 7)) begin
        e_ack = 1; m_full = 1; m_match = 1; m_rw = 0;
      end
    end
  endtask

  task automatic check_out(input string req);
    checks++;
    if ({ack_vld, ack, matched, gcall_hit, rw_bit} !== {e_av, e_ack, m_match, m_gc, m_rw}) begin
      errors++;
      $display("FAIL %s: actual vld/ack/match/gc/rw=%b expected %b", req,
               {ack_vld, ack, matched, gcall_hit, rw_bit}, {e_av, e_ack, m_match, m_gc, m_rw});
    end
  endtask

  // Called right after a negedge: drive, run model, sample at the next negedge.
  task automatic send(input logic f, input logic s, input logic [7:0] b, input string req);
    byte_vld = !s; addr_first = f; stop_det = s; rx_byte = b;
    model(f, s, b);
    @(negedge clk);
    check_out(req);
    byte_vld = 0; addr_first = 0; stop_det = 0;
  endtask

  task automatic cfg(input logic [9:0] own, msk, input logic ten, gce, mg);
    own_addr = own; addr_mask = msk; ten_bit_en = ten; gcall_en = gce; mgmt_en = mg;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    e_av = 0; e_ack = 0;
    check_out("R11");

    // R1: mask makes bit 5 a don't-care
    cfg(10'h000, 10'h020, 0, 0, 0);
    send(1, 0, 8'h40, "R1");
    send(1, 0, 8'h41, "R1/R10");
    // R2: management mode drops the mask
    cfg(10'h000, 10'h020, 0, 0, 1);
    send(1, 0, 8'h40, "R2");
    // R3: general call gated
    send(1, 0, 8'h00, "R3");
    cfg(10'h000, 10'h020, 0, 1, 0);
    send(1, 0, 8'h00, "R3");
    // R4: reserved bytes with all-ones mask
    cfg(10'h000, 10'h3FF, 0, 1, 0);
    send(1, 0, 8'h01, "R4");
    send(1, 0, 8'h06, "R4");
    send(1, 0, 8'h0F, "R4");
    send(1, 0, 8'hFA, "R4");
    // R5: 11110xx in 7-bit mode
    send(1, 0, 8'hF2, "R5");
    // R10: plain 7-bit match with read
    cfg(10'h055, 10'h000, 0, 0, 0);
    send(1, 0, 8'hAB, "R10");
    send(0, 0, 8'h12, "R9");
    // R9: idle cycle drops ack_vld
    e_av = 0; e_ack = 0;
    @(negedge clk);
    check_out("R9");
    // R6/R7: 10-bit sequence
    cfg(10'h2C5, 10'h000, 1, 0, 0);
    send(1, 0, 8'hF4, "R6");
    send(0, 0, 8'hC5, "R6");
    send(1, 0, 8'hF5, "R7");
    send(0, 0, 8'h33, "R9");
    // R8: stop clears, read then refused
    send(0, 1, 8'h00, "R8");
    send(1, 0, 8'hF5, "R7/R8");
    // R8: failed first byte clears partial
    send(1, 0, 8'hF4, "R6");
    send(1, 0, 8'hF0, "R8");
    send(0, 0, 8'hC5, "R8");
    // R5: plain address in 10-bit mode refused
    send(1, 0, 8'h8A, "R5");
    // R1 in 10-bit mode: mask on A8 and A0
    cfg(10'h2C5, 10'h101, 1, 0, 0);
    send(1, 0, 8'hF6, "R1");
    send(0, 0, 8'hC4, "R1");

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      logic [9:0] own;
      logic [7:0] b;
      int kind;
      if (it % 50 == 0) begin
        own = 10'($urandom);
        cfg(own, 10'($urandom) & 10'($urandom) & 10'($urandom),
            1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      end
      kind = $urandom % 8;
      case (kind)
        0: b = {own_addr[6:0] ^ 7'(1 << ($urandom % 7)), 1'($urandom)};
        1: b = {own_addr[6:0], 1'($urandom)};
        2: b = {5'b11110, own_addr[9:8], 1'b0};
        3: b = {5'b11110, own_addr[9:8], 1'b1};
        4: b = own_addr[7:0];
        5: b = 8'($urandom % 2);
        default: b = 8'($urandom);
      endcase
      if ($urandom % 16 == 0) send(0, 1, 8'h00, "R8");
      else if (kind == 4 || $urandom % 5 == 0) send(0, 0, b, "R6");
      else send(1, 0, b, "R1/R10");
    end

    // R11: reset mid-state
    cfg(10'h055, 10'h000, 0, 0, 0);
    send(1, 0, 8'hAB, "R10");
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_hi = 0; m_full = 0; m_match = 0; m_gc = 0; m_rw = 0; e_av = 0; e_ack = 0;
    check_out("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule